// File: doc/BRIEF.md
# Selectable Round, Window and Clamp Output Stage

This stage conditions the wide result of a filter accumulator before it leaves the filter. Each clock it can accept a 32-bit result together with a 4-bit bank index. Three steps act on the result. First a rounding constant is added. Next a 12-bit field is taken from a programmable bit position. Last, the field can be clamped between a lower and an upper bound. Each step has its own bank of sixteen entries, and all three banks are addressed by the index that arrives with the sample. The index may change on every sample, so interleaved streams can each use their own rounding, scaling and limits.

The banks and one control register are loaded through a 16-bit write port. The write address is 7 bits wide: bits [6:5] pick the target (0 rounding, 1 window, 2 limits, 3 control), bits [4:1] pick the entry, and bit 0 picks the half. A rounding constant is written as two halves: low half (bit 0 = 0) first, then high half (bit 0 = 1). A limit entry is written the same way, with the lower bound in the first write (data[11:0]) and the upper bound in the second. The value takes effect on the second write. A window entry takes data[4:0] in a single write. The control register takes a single write to entry 0, half 0, and its bit 1 enables clamping.

Top module: `out_cond_stage`

## Requirements
- R1: After reset, outValid and outData are 0. Every rounding entry is 0, every window entry is 0, every limit entry is lower 0 and upper 0xFFF, and clamping is off. In this state the output equals bits [11:0] of the input.
- R2: A sample presented with inValid high at a clock edge appears at outValid/outData after the second edge that follows. There are three register stages, so outValid equals inValid delayed by three cycles. While outValid is low, outData holds its last value.
- R3: The rounding entry chosen by the sample's index is added to the 32-bit input, and the sum wraps modulo 2^32.
- R4: Window entry value k passes bits [k+11:k] of the rounded sum.
- R5: Window values above 20 act as 20, so the field never runs past bit 31.
- R6: Index value n selects entry n of all three banks. Consecutive samples with different indices each use their own entries.
- R7: With control bit 1 set, an unsigned field below the lower bound outputs the lower bound. A field above the upper bound outputs the upper bound. Any other field passes unchanged, including values equal to either bound.
- R8: With control bit 1 clear, the bounds have no effect.
- R9: A rounding entry is unchanged by its low-half write alone. The high-half write commits {high, low}.
- R10: A limit entry is unchanged by its lower-bound write alone. The upper-bound write commits both bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Write address: target [6:5], entry [4:1], half [0] |
| wrData | input | 16 | Write data |
| inValid | input | 1 | Input sample valid |
| inData | input | 32 | Filter result |
| inSel | input | 4 | Bank index for this sample |
| outValid | output | 1 | Output sample valid |
| outData | output | 12 | Rounded, windowed and clamped output |

## Verification
The bench builds the stage with its default parameters: a 32-bit input, a 12-bit output and sixteen entries per bank. The largest legal window position is therefore 20, and the 5-bit window field reaches 31. Two sweeps program window positions 0 through 31 across the sixteen entries, which covers every legal position and every saturated one. Each sweep feeds streams whose index changes every sample. Clamping is checked with random bounds and with directed samples at, just below and just above each bound. Split writes are checked by looking at the output after the first half has been written and again after the second.

// File: rtl/out_cond_pkg.sv
`timescale 1ns/1ps
package out_cond_pkg;
  localparam int ENTRY_W = 4;
  localparam int ENTRIES = 1 << ENTRY_W;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = ENTRY_W + 3;
  localparam int VAL_W   = 2 * WORD_W;

  typedef enum logic [1:0] {
    BANK_RND = 2'd0,
    BANK_WIN = 2'd1,
    BANK_LIM = 2'd2,
    BANK_CTL = 2'd3
  } bank_e;

  typedef struct packed {
    logic               wrRnd;
    logic               wrWin;
    logic               wrLim;
    logic               wrCtl;
    logic [ENTRY_W-1:0] entry;
    logic [VAL_W-1:0]   value;
  } cfg_strobe_t;
endpackage

// File: rtl/out_cond_ctrl.sv
`timescale 1ns/1ps
module out_cond_ctrl
  import out_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output cfg_strobe_t       strobe
);
  bank_e bank;
  logic hiHalf;
  logic splitBank;
  logic [WORD_W-1:0] holdLo;

  assign bank      = bank_e'(wrAddr[ADDR_W-1 -: 2]);
  assign hiHalf    = wrAddr[0];
  assign splitBank = (bank == BANK_RND) || (bank == BANK_LIM);

  // first half of a split value waits here for its partner
  always_ff @(posedge clk) begin
    if (!rstN) holdLo <= '0;
    else if (wrEn && splitBank && !hiHalf) holdLo <= wrData;
  end

  always_comb begin
    strobe.wrRnd = wrEn && (bank == BANK_RND) && hiHalf;
    strobe.wrLim = wrEn && (bank == BANK_LIM) && hiHalf;
    strobe.wrWin = wrEn && (bank == BANK_WIN);
    strobe.wrCtl = wrEn && (bank == BANK_CTL);
    strobe.entry = wrAddr[ENTRY_W:1];
    strobe.value = splitBank ? {wrData, holdLo} : {{WORD_W{1'b0}}, wrData};
  end
endmodule

// File: rtl/out_cond_dp.sv
`timescale 1ns/1ps
module out_cond_dp
  import out_cond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfg_strobe_t        strobe,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [ENTRY_W-1:0] inSel,
  output logic               outValid,
  output logic [OUT_W-1:0]   outData
);
  localparam int POS_W   = $clog2(DATA_W);
  localparam int MAX_POS = DATA_W - OUT_W;
  localparam logic [POS_W-1:0] MAX_POS_V = POS_W'(MAX_POS);

  logic [DATA_W-1:0] rndBank [ENTRIES];
  logic [POS_W-1:0]  winBank [ENTRIES];
  logic [OUT_W-1:0]  loBank  [ENTRIES];
  logic [OUT_W-1:0]  hiBank  [ENTRIES];
  logic              limOn;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rndBank[e] <= '0;
        winBank[e] <= '0;
        loBank[e]  <= '0;
        hiBank[e]  <= '1;
      end else if (strobe.entry == ENTRY_W'(e)) begin
        if (strobe.wrRnd) rndBank[e] <= strobe.value[DATA_W-1:0];
        if (strobe.wrWin) winBank[e] <= strobe.value[POS_W-1:0];
        if (strobe.wrLim) begin
          loBank[e] <= strobe.value[OUT_W-1:0];
          hiBank[e] <= strobe.value[WORD_W +: OUT_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) limOn <= 1'b0;
    else if (strobe.wrCtl) limOn <= strobe.value[1];
  end

  // stage 1: rounding add
  logic               s1Valid;
  logic [DATA_W-1:0]  s1Sum;
  logic [ENTRY_W-1:0] s1Sel;
  // stage 2: window
  logic               s2Valid;
  logic [OUT_W-1:0]   s2Win;
  logic [ENTRY_W-1:0] s2Sel;

  logic [POS_W-1:0]  posSat;
  logic [DATA_W-1:0] shifted;
  logic [OUT_W-1:0]  curLo, curHi, clampVal;

  always_comb begin
    posSat  = (winBank[s1Sel] > MAX_POS_V) ? MAX_POS_V : winBank[s1Sel];
    shifted = s1Sum >> posSat;
    curLo   = loBank[s2Sel];
    curHi   = hiBank[s2Sel];
    if (limOn && (s2Win < curLo))      clampVal = curLo;
    else if (limOn && (s2Win > curHi)) clampVal = curHi;
    else                               clampVal = s2Win;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Sum    <= '0;
      s1Sel    <= '0;
      s2Valid  <= 1'b0;
      s2Win    <= '0;
      s2Sel    <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      s1Valid  <= inValid;
      s2Valid  <= s1Valid;
      outValid <= s2Valid;
      if (inValid) begin
        s1Sum <= inData + rndBank[inSel];
        s1Sel <= inSel;
      end
      if (s1Valid) begin
        s2Win <= shifted[OUT_W-1:0];
        s2Sel <= s1Sel;
      end
      if (s2Valid) outData <= clampVal;
    end
  end
endmodule

// File: rtl/out_cond_stage.sv
`timescale 1ns/1ps
module out_cond_stage
  import out_cond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [ENTRY_W-1:0] inSel,
  output logic               outValid,
  output logic [OUT_W-1:0]   outData
);
  cfg_strobe_t strobe;

  out_cond_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  out_cond_dp #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inValid  (inValid),
    .inData   (inData),
    .inSel    (inSel),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/out_cond_chk.sv
`timescale 1ns/1ps
module out_cond_chk
  import out_cond_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               inValid,
  input logic               outValid,
  input logic [OUT_W-1:0]   outData,
  input cfg_strobe_t        strobe,
  input logic               limOn,
  input logic [OUT_W-1:0]   curLo,
  input logic [OUT_W-1:0]   curHi
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outData));

  // R7
  clamp_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && outValid && $past(limOn) && $past(curLo <= curHi))
      |-> (outData >= $past(curLo) && outData <= $past(curHi)));

  // R9
  split_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrRnd || strobe.wrLim) |-> (wrEn && wrAddr[0]));

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRnd, strobe.wrWin, strobe.wrLim, strobe.wrCtl}));
endmodule

bind out_cond_stage out_cond_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData),
  .strobe   (strobe),
  .limOn    (u_dp.limOn),
  .curLo    (u_dp.curLo),
  .curHi    (u_dp.curHi)
);

// File: tb/tb_out_cond_stage.sv
`timescale 1ns/1ps
module tb_out_cond_stage;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [3:0]  inSel = '0;
  logic        outValid;
  logic [11:0] outData;

  out_cond_stage dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inValid(inValid), .inData(inData), .inSel(inSel),
    .outValid(outValid), .outData(outData)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mRnd [16];
  logic [4:0]  mWin [16];
  logic [11:0] mLo  [16];
  logic [11:0] mHi  [16];
  logic        mLim;

  logic [11:0] expD [0:255];
  logic        expV [0:255];
  logic [31:0] dirData [0:15];
  logic [11:0] lastOut = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setRound(int e, logic [31:0] v);
    wr({2'd0, 4'(e), 1'b0}, v[15:0]);
    wr({2'd0, 4'(e), 1'b1}, v[31:16]);
    mRnd[e] = v;
  endtask

  task automatic setWin(int e, logic [4:0] k);
    wr({2'd1, 4'(e), 1'b0}, {11'd0, k});
    mWin[e] = k;
  endtask

  task automatic setLim(int e, logic [11:0] lo, logic [11:0] hi);
    wr({2'd2, 4'(e), 1'b0}, {4'd0, lo});
    wr({2'd2, 4'(e), 1'b1}, {4'd0, hi});
    mLo[e] = lo; mHi[e] = hi;
  endtask

  task automatic setCtl(logic en);
    wr({2'd3, 4'd0, 1'b0}, {14'd0, en, 1'b0});
    mLim = en;
  endtask

  function automatic logic [11:0] model(logic [31:0] d, logic [3:0] i);
    logic [31:0] s;
    int k;
    logic [11:0] w;
    s = d + mRnd[i];
    k = (mWin[i] > 5'd20) ? 20 : int'(mWin[i]);
    w = 12'((s >> k) & 32'hFFF);
    if (mLim && w < mLo[i]) w = mLo[i];
    else if (mLim && w > mHi[i]) w = mHi[i];
    return w;
  endfunction

  // n samples; fixIdx < 0 means random index; useDir takes data from dirData
  task automatic stream(int n, string tag, int fixIdx, bit useDir);
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        check({tag, " valid"}, {31'd0, outValid}, {31'd0, expV[c-3]});
        if (expV[c-3]) begin
          check({tag, " data"}, {20'd0, outData}, {20'd0, expD[c-3]});
          lastOut = expD[c-3];
        end else begin
          check({tag, " R2 hold"}, {20'd0, outData}, {20'd0, lastOut});
        end
      end
      if (c < n) begin
        logic [31:0] d;
        logic [3:0]  ix;
        d  = useDir ? dirData[c % 16] : $urandom;
        ix = (fixIdx < 0) ? 4'($urandom) : 4'(fixIdx);
        expV[c] = ((c % 7) != 4);
        expD[c] = model(d, ix);
        inValid = expV[c]; inData = d; inSel = ix;
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) begin
      mRnd[e] = '0; mWin[e] = '0; mLo[e] = '0; mHi[e] = 12'hFFF;
    end
    mLim = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R1 reset data", {20'd0, outData}, 32'd0);
    rstN = 1'b1;

    stream(40, "R1 defaults", -1, 1'b0);

    for (int e = 0; e < 16; e++) begin
      setRound(e, $urandom);
      setWin(e, 5'(e));
      setLim(e, 12'h200 + 12'($urandom % 256), 12'hA00 + 12'($urandom % 256));
    end
    setRound(1, 32'hFFFF_FFFF);
    stream(200, "R3/R4/R6/R8", -1, 1'b0);

    for (int e = 0; e < 16; e++) setWin(e, 5'(16 + e));
    stream(200, "R5/R6", -1, 1'b0);

    for (int e = 0; e < 16; e++) setWin(e, 5'(e));
    setCtl(1'b1);
    stream(200, "R7", -1, 1'b0);

    setRound(0, 32'd0); setWin(0, 5'd0); setLim(0, 12'h100, 12'h200);
    dirData[0] = 32'h0FF;  dirData[1] = 32'h100;  dirData[2] = 32'h101;
    dirData[3] = 32'h1FF;  dirData[4] = 32'h200;  dirData[5] = 32'h201;
    dirData[6] = 32'h000;  dirData[7] = 32'hFFF;  dirData[8] = 32'h150;
    dirData[9] = 32'h1_0080; dirData[10] = 32'h1_0250; dirData[11] = 32'h180;
    dirData[12] = 32'h0FE; dirData[13] = 32'h202; dirData[14] = 32'h001;
    dirData[15] = 32'hABC;
    stream(32, "R7 edges", 0, 1'b1);

    setCtl(1'b0);
    stream(32, "R8 bounds off", 0, 1'b1);

    setWin(3, 5'd0);
    setRound(3, 32'h0000_0010);
    wr({2'd0, 4'd3, 1'b0}, 16'h0800);
    stream(20, "R9 low only", 3, 1'b0);
    wr({2'd0, 4'd3, 1'b1}, 16'h0000);
    mRnd[3] = 32'h0000_0800;
    stream(20, "R9 committed", 3, 1'b0);

    setCtl(1'b1);
    setRound(3, 32'd0);
    setLim(3, 12'h000, 12'hFFF);
    wr({2'd2, 4'd3, 1'b0}, 16'h0400);
    stream(20, "R10 lower only", 3, 1'b0);
    wr({2'd2, 4'd3, 1'b1}, 16'h0600);
    mLo[3] = 12'h400; mHi[3] = 12'h600;
    stream(20, "R10 committed", 3, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule